// File: doc/BRIEF.md
# USB High-Speed PHY Power Sequencer

This block is a hardware state machine that brings a high-speed USB PHY up and takes it down again, replacing a firmware routine of register writes and delays. It drives every PHY and link control line as a registered output: the clock-gating override, the PHY, port and link resets, the UTMI force controls, the D+ and D- pulldowns, the VBUS-valid overrides, the analog power-down and the full-speed single-ended output enable. There is no register bus. A one-cycle `initReq` pulse starts the power-up sequence and a one-cycle `exitReq` pulse starts the power-down sequence.

Each step of a sequence takes one clock cycle. The two timed holds around the PHY power-on-reset release, and the link reset pulse on exit, are counted in clock cycles. One shared down-counter sets their length from the `CLK_MHZ` parameter. `busy` shows that a sequence is in progress, `done` marks its completion, and requests that arrive while `busy` is high are dropped.

Top module: `usb_phy_pwr_seq`

## Requirements
- R1: While `rstN` is low, and on the first cycles after it rises, `analogPwrDn`, `forceSuspend`, `forceSleep` and `seOutEn` are 1. Every other output, including `busy` and `done`, is 0, and `filterBypass` is 4'b0000. Pulling `rstN` low in the middle of a sequence returns all outputs to these values at once.
- R2: An init request accepted at edge 0 sets `qActiveForce` at edge 1. It then sets `phyPor` and `portRst` together at edge 2, before any UTMI or high-speed control output changes.
- R3: At init edge 3, `forceSuspend`, `forceSleep`, `dpPullDn` and `dmPullDn` go to 0. At edge 4, `suspendEn` and `commonOn` go to 1.
- R4: At init edge 5, `filterBypass` becomes all ones. At edge 6, `forceBvalid` and `forceVbusValid` go to 1. At edge 7, `vbusExtVal` and `vbusExtSel` go to 1.
- R5: At init edge 8, `analogPwrDn` goes to 0. Exactly 10*CLK_MHZ edges later, `phyPor` and `portRst` both go to 0 on the same edge.
- R6: Exactly 75*CLK_MHZ edges after the reset release, `seOutEn` goes to 0. This is the last init step.
- R7: An exit request accepted at edge 0 works as follows. At edge 1, `dpPullDn` and `dmPullDn` go to 0 and `forceSuspend` and `forceSleep` go to 1. At edge 2, `analogPwrDn` goes to 1. At edge 3, `linkRst` goes to 1, and it returns to 0 exactly 10*CLK_MHZ edges later, which is the last exit step.
- R8: `busy` is 1 from the edge that accepts a request up to, but not including, the edge that performs the final step. `done` is 1 for exactly the one cycle that follows the final step.
- R9: Any `initReq` or `exitReq` pulse while `busy` is 1 has no effect on any output.
- R10: If `initReq` and `exitReq` are both 1 in the same idle cycle, the init sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rstN | input | 1 | Asynchronous active-low reset |
| initReq | input | 1 | One-cycle power-up request |
| exitReq | input | 1 | One-cycle power-down request |
| qActiveForce | output | 1 | Holds the clock-gating handshake active so the PHY clock keeps running |
| phyPor | output | 1 | PHY power-on software reset |
| portRst | output | 1 | Port reset |
| linkRst | output | 1 | Link software reset |
| forceSuspend | output | 1 | UTMI force suspend |
| forceSleep | output | 1 | UTMI force sleep |
| dpPullDn | output | 1 | D+ pulldown enable |
| dmPullDn | output | 1 | D- pulldown enable |
| forceBvalid | output | 1 | Forces B-session valid |
| forceVbusValid | output | 1 | Forces VBUS valid |
| suspendEn | output | 1 | Lets UTMI suspend control the PHY |
| commonOn | output | 1 | Keeps the PHY common block powered |
| filterBypass | output | 4 | Bus-filter bypass controls |
| vbusExtVal | output | 1 | External VBUS-valid value |
| vbusExtSel | output | 1 | Selects the external VBUS-valid value |
| analogPwrDn | output | 1 | Analog power-down (quiescent current mode) |
| seOutEn | output | 1 | Full-speed single-ended output enable |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
Every cycle of every sequence is compared in full with a cycle-indexed model of the step order. A swapped step, an off-by-one hold, or a reset released apart from its partner therefore shows up on the exact edge where it happens. The patterns are: exit straight from reset, where the outputs start in their power-down state; init after exit, and init after init, where the same step moves different outputs; and random sequences with stray requests of both kinds injected mid-sequence, which separate dropped requests from restarts. Directed cases cover simultaneous requests, which separate init priority from exit priority, and a reset asserted mid-init, which shows that recovery is immediate rather than waiting for a step boundary.

// File: rtl/usb_phy_pwr_pkg.sv
package usb_phy_pwr_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_I_QACT,
    ST_I_POR,
    ST_I_UTMI,
    ST_I_HSP,
    ST_I_FILT,
    ST_I_FORCE,
    ST_I_VEXT,
    ST_I_PWRUP,
    ST_I_WAITPRE,
    ST_I_REL,
    ST_I_WAITPOST,
    ST_I_SEOFF,
    ST_E_UTMI,
    ST_E_PWRDN,
    ST_E_LRST,
    ST_E_WAIT,
    ST_E_LREL
  } seqState_t;

  // one strobe per sequence step, issued by control, applied by datapath
  typedef struct packed {
    logic setQact;
    logic holdPor;
    logic utmiRun;
    logic hspOn;
    logic filtOn;
    logic forceOn;
    logic vextOn;
    logic pwrUp;
    logic relPor;
    logic seOff;
    logic utmiPark;
    logic pwrDn;
    logic linkOn;
    logic linkOff;
    logic cntDec;
  } seqStrobe_t;

  function automatic int usToCycles(input int us, input int mhz);
    return us * mhz;
  endfunction

endpackage

// File: rtl/usb_phy_pwr_ctrl.sv
module usb_phy_pwr_ctrl
  import usb_phy_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       initReq,
  input  logic       exitReq,
  input  logic       cntZero,
  output seqStrobe_t str,
  output logic       busy,
  output logic       done
);

  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:       if (initReq) stateNxt = ST_I_QACT;
                     else if (exitReq) stateNxt = ST_E_UTMI;
      ST_I_QACT:     stateNxt = ST_I_POR;
      ST_I_POR:      stateNxt = ST_I_UTMI;
      ST_I_UTMI:     stateNxt = ST_I_HSP;
      ST_I_HSP:      stateNxt = ST_I_FILT;
      ST_I_FILT:     stateNxt = ST_I_FORCE;
      ST_I_FORCE:    stateNxt = ST_I_VEXT;
      ST_I_VEXT:     stateNxt = ST_I_PWRUP;
      ST_I_PWRUP:    stateNxt = ST_I_WAITPRE;
      ST_I_WAITPRE:  if (cntZero) stateNxt = ST_I_REL;
      ST_I_REL:      stateNxt = ST_I_WAITPOST;
      ST_I_WAITPOST: if (cntZero) stateNxt = ST_I_SEOFF;
      ST_I_SEOFF:    stateNxt = ST_IDLE;
      ST_E_UTMI:     stateNxt = ST_E_PWRDN;
      ST_E_PWRDN:    stateNxt = ST_E_LRST;
      ST_E_LRST:     stateNxt = ST_E_WAIT;
      ST_E_WAIT:     if (cntZero) stateNxt = ST_E_LREL;
      ST_E_LREL:     stateNxt = ST_IDLE;
      default:       stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    str          = '0;
    str.setQact  = (state == ST_I_QACT);
    str.holdPor  = (state == ST_I_POR);
    str.utmiRun  = (state == ST_I_UTMI);
    str.hspOn    = (state == ST_I_HSP);
    str.filtOn   = (state == ST_I_FILT);
    str.forceOn  = (state == ST_I_FORCE);
    str.vextOn   = (state == ST_I_VEXT);
    str.pwrUp    = (state == ST_I_PWRUP);
    str.relPor   = (state == ST_I_REL);
    str.seOff    = (state == ST_I_SEOFF);
    str.utmiPark = (state == ST_E_UTMI);
    str.pwrDn    = (state == ST_E_PWRDN);
    str.linkOn   = (state == ST_E_LRST);
    str.linkOff  = (state == ST_E_LREL);
    str.cntDec   = !cntZero && (state == ST_I_WAITPRE || state == ST_I_WAITPOST ||
                                state == ST_E_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= (state == ST_I_SEOFF) || (state == ST_E_LREL);
    end
  end

  assign busy = (state != ST_IDLE);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_init_priority_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && initReq) |=> (state == ST_I_QACT));

  assert_busy_drops_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != ST_I_SEOFF && state != ST_E_LREL) |=> busy);

endmodule

// File: rtl/usb_phy_pwr_dp.sv
module usb_phy_pwr_dp
  import usb_phy_pwr_pkg::*;
#(
  parameter int CLK_MHZ     = 250,
  parameter int PRE_REL_US  = 10,
  parameter int POST_REL_US = 75,
  parameter int LINK_RST_US = 10,
  parameter int FILT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        str,
  output logic              cntZero,
  output logic              qActiveForce,
  output logic              phyPor,
  output logic              portRst,
  output logic              linkRst,
  output logic              forceSuspend,
  output logic              forceSleep,
  output logic              dpPullDn,
  output logic              dmPullDn,
  output logic              forceBvalid,
  output logic              forceVbusValid,
  output logic              suspendEn,
  output logic              commonOn,
  output logic [FILT_W-1:0] filterBypass,
  output logic              vbusExtVal,
  output logic              vbusExtSel,
  output logic              analogPwrDn,
  output logic              seOutEn
);

  localparam int PRE_CYC  = usToCycles(PRE_REL_US, CLK_MHZ);
  localparam int POST_CYC = usToCycles(POST_REL_US, CLK_MHZ);
  localparam int LINK_CYC = usToCycles(LINK_RST_US, CLK_MHZ);
  localparam int MAX_CYC  = (POST_CYC > PRE_CYC) ?
                            ((POST_CYC > LINK_CYC) ? POST_CYC : LINK_CYC) :
                            ((PRE_CYC > LINK_CYC) ? PRE_CYC : LINK_CYC);
  localparam int CW       = $clog2(MAX_CYC + 1);
  // a hold state plus the step that ends it make up two of the cycles
  localparam logic [CW-1:0] PRE_LOAD  = CW'(PRE_CYC - 2);
  localparam logic [CW-1:0] POST_LOAD = CW'(POST_CYC - 2);
  localparam logic [CW-1:0] LINK_LOAD = CW'(LINK_CYC - 2);

  logic [CW-1:0] waitCnt;

  initial begin
    if (PRE_CYC < 2 || POST_CYC < 2 || LINK_CYC < 2)
      $error("hold lengths must be at least two cycles");
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (str.pwrUp) begin
      waitCnt <= PRE_LOAD;
    end else if (str.relPor) begin
      waitCnt <= POST_LOAD;
    end else if (str.linkOn) begin
      waitCnt <= LINK_LOAD;
    end else if (str.cntDec) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign cntZero = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qActiveForce   <= 1'b0;
      phyPor         <= 1'b0;
      portRst        <= 1'b0;
      linkRst        <= 1'b0;
      forceSuspend   <= 1'b1;
      forceSleep     <= 1'b1;
      dpPullDn       <= 1'b0;
      dmPullDn       <= 1'b0;
      forceBvalid    <= 1'b0;
      forceVbusValid <= 1'b0;
      suspendEn      <= 1'b0;
      commonOn       <= 1'b0;
      filterBypass   <= '0;
      vbusExtVal     <= 1'b0;
      vbusExtSel     <= 1'b0;
      analogPwrDn    <= 1'b1;
      seOutEn        <= 1'b1;
    end else begin
      if (str.setQact) qActiveForce <= 1'b1;
      if (str.holdPor) begin
        phyPor  <= 1'b1;
        portRst <= 1'b1;
      end
      if (str.utmiRun) begin
        forceSuspend <= 1'b0;
        forceSleep   <= 1'b0;
        dpPullDn     <= 1'b0;
        dmPullDn     <= 1'b0;
      end
      if (str.hspOn) begin
        suspendEn <= 1'b1;
        commonOn  <= 1'b1;
      end
      if (str.filtOn) filterBypass <= '1;
      if (str.forceOn) begin
        forceBvalid    <= 1'b1;
        forceVbusValid <= 1'b1;
      end
      if (str.vextOn) begin
        vbusExtVal <= 1'b1;
        vbusExtSel <= 1'b1;
      end
      if (str.pwrUp) analogPwrDn <= 1'b0;
      if (str.relPor) begin
        phyPor  <= 1'b0;
        portRst <= 1'b0;
      end
      if (str.seOff) seOutEn <= 1'b0;
      if (str.utmiPark) begin
        dpPullDn     <= 1'b0;
        dmPullDn     <= 1'b0;
        forceSuspend <= 1'b1;
        forceSleep   <= 1'b1;
      end
      if (str.pwrDn) analogPwrDn <= 1'b1;
      if (str.linkOn) linkRst <= 1'b1;
      if (str.linkOff) linkRst <= 1'b0;
    end
  end

  assert_por_before_cfg_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(forceSuspend) || $rose(suspendEn)) |-> phyPor);

  assert_vext_after_force_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vbusExtSel) |-> (forceVbusValid && (&filterBypass)));

  assert_pwrup_under_por_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(analogPwrDn) |-> (phyPor && vbusExtSel));

  assert_resets_release_together_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyPor) |-> $fell(portRst));

  assert_se_after_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seOutEn) |-> (!phyPor && !analogPwrDn));

  assert_link_pulse_powered_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkRst) |-> (analogPwrDn && forceSuspend));

endmodule

// File: rtl/usb_phy_pwr_seq.sv
module usb_phy_pwr_seq
  import usb_phy_pwr_pkg::*;
#(
  parameter int CLK_MHZ     = 250,
  parameter int PRE_REL_US  = 10,
  parameter int POST_REL_US = 75,
  parameter int LINK_RST_US = 10,
  parameter int FILT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic              exitReq,
  output logic              qActiveForce,
  output logic              phyPor,
  output logic              portRst,
  output logic              linkRst,
  output logic              forceSuspend,
  output logic              forceSleep,
  output logic              dpPullDn,
  output logic              dmPullDn,
  output logic              forceBvalid,
  output logic              forceVbusValid,
  output logic              suspendEn,
  output logic              commonOn,
  output logic [FILT_W-1:0] filterBypass,
  output logic              vbusExtVal,
  output logic              vbusExtSel,
  output logic              analogPwrDn,
  output logic              seOutEn,
  output logic              busy,
  output logic              done
);

  seqStrobe_t str;
  logic       cntZero;

  usb_phy_pwr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .initReq (initReq),
    .exitReq (exitReq),
    .cntZero (cntZero),
    .str     (str),
    .busy    (busy),
    .done    (done)
  );

  usb_phy_pwr_dp #(
    .CLK_MHZ     (CLK_MHZ),
    .PRE_REL_US  (PRE_REL_US),
    .POST_REL_US (POST_REL_US),
    .LINK_RST_US (LINK_RST_US),
    .FILT_W      (FILT_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .str            (str),
    .cntZero        (cntZero),
    .qActiveForce   (qActiveForce),
    .phyPor         (phyPor),
    .portRst        (portRst),
    .linkRst        (linkRst),
    .forceSuspend   (forceSuspend),
    .forceSleep     (forceSleep),
    .dpPullDn       (dpPullDn),
    .dmPullDn       (dmPullDn),
    .forceBvalid    (forceBvalid),
    .forceVbusValid (forceVbusValid),
    .suspendEn      (suspendEn),
    .commonOn       (commonOn),
    .filterBypass   (filterBypass),
    .vbusExtVal     (vbusExtVal),
    .vbusExtSel     (vbusExtSel),
    .analogPwrDn    (analogPwrDn),
    .seOutEn        (seOutEn)
  );

endmodule

// File: tb/usb_phy_pwr_seq_tb.sv
`timescale 1ns/1ps
module usb_phy_pwr_seq_tb;

  localparam int CLK_MHZ = 20;
  localparam int N_PRE   = 10 * CLK_MHZ;
  localparam int N_POST  = 75 * CLK_MHZ;
  localparam int N_LINK  = 10 * CLK_MHZ;
  localparam int T_INIT  = 8 + N_PRE + N_POST;
  localparam int T_EXIT  = 3 + N_LINK;

  typedef struct packed {
    logic qAct, por, portRst, linkRst, fSusp, fSleep, dpPd, dmPd;
    logic fBval, fVbus, suspEn, commonOn;
    logic [3:0] filt;
    logic vVal, vSel, pwrDn, seOut, busy, done;
  } outs_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 1'b0;
  logic exitReq = 1'b0;
  logic qActiveForce, phyPor, portRst, linkRst, forceSuspend, forceSleep;
  logic dpPullDn, dmPullDn, forceBvalid, forceVbusValid, suspendEn, commonOn;
  logic [3:0] filterBypass;
  logic vbusExtVal, vbusExtSel, analogPwrDn, seOutEn, busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  outs_t cur;

  always #2 clk = ~clk;

  usb_phy_pwr_seq #(.CLK_MHZ(CLK_MHZ)) u_dut (
    .clk(clk), .rstN(rstN), .initReq(initReq), .exitReq(exitReq),
    .qActiveForce(qActiveForce), .phyPor(phyPor), .portRst(portRst),
    .linkRst(linkRst), .forceSuspend(forceSuspend), .forceSleep(forceSleep),
    .dpPullDn(dpPullDn), .dmPullDn(dmPullDn), .forceBvalid(forceBvalid),
    .forceVbusValid(forceVbusValid), .suspendEn(suspendEn), .commonOn(commonOn),
    .filterBypass(filterBypass), .vbusExtVal(vbusExtVal), .vbusExtSel(vbusExtSel),
    .analogPwrDn(analogPwrDn), .seOutEn(seOutEn), .busy(busy), .done(done)
  );

  function automatic outs_t observed();
    return {qActiveForce, phyPor, portRst, linkRst, forceSuspend, forceSleep,
            dpPullDn, dmPullDn, forceBvalid, forceVbusValid, suspendEn, commonOn,
            filterBypass, vbusExtVal, vbusExtSel, analogPwrDn, seOutEn, busy, done};
  endfunction

  function automatic outs_t resetVec();
    outs_t r = '0;
    r.fSusp = 1'b1; r.fSleep = 1'b1; r.pwrDn = 1'b1; r.seOut = 1'b1;
    return r;
  endfunction

  // expected outputs k edges after the accepting edge
  function automatic outs_t expectAt(outs_t s, bit isInit, int k);
    outs_t e = s;
    int t;
    if (isInit) begin
      t = T_INIT;
      if (k >= 1) e.qAct = 1'b1;
      if (k >= 2) begin e.por = 1'b1; e.portRst = 1'b1; end
      if (k >= 3) begin e.fSusp = 1'b0; e.fSleep = 1'b0; e.dpPd = 1'b0; e.dmPd = 1'b0; end
      if (k >= 4) begin e.suspEn = 1'b1; e.commonOn = 1'b1; end
      if (k >= 5) e.filt = 4'hF;
      if (k >= 6) begin e.fBval = 1'b1; e.fVbus = 1'b1; end
      if (k >= 7) begin e.vVal = 1'b1; e.vSel = 1'b1; end
      if (k >= 8) e.pwrDn = 1'b0;
      if (k >= 8 + N_PRE) begin e.por = 1'b0; e.portRst = 1'b0; end
      if (k >= t) e.seOut = 1'b0;
    end else begin
      t = T_EXIT;
      if (k >= 1) begin e.dpPd = 1'b0; e.dmPd = 1'b0; e.fSusp = 1'b1; e.fSleep = 1'b1; end
      if (k >= 2) e.pwrDn = 1'b1;
      if (k >= 3) e.linkRst = 1'b1;
      if (k >= t) e.linkRst = 1'b0;
    end
    e.busy = (k < t);
    e.done = (k == t);
    return e;
  endfunction

  function automatic string tagFor(bit isInit, int k);
    if (!isInit) return "R7";
    if (k <= 2) return "R2";
    if (k <= 4) return "R3";
    if (k <= 7) return "R4";
    if (k < 8 + N_PRE + 1) return "R5";
    if (k <= T_INIT) return "R6";
    return "R8";
  endfunction

  task automatic check(input string tag, input outs_t exp);
    outs_t act = observed();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // drive a request (both = assert init and exit together), then compare every cycle
  task automatic runSeq(input bit isInit, input bit both, input int injectPct);
    int t = isInit ? T_INIT : T_EXIT;
    bit injected = 1'b0;
    outs_t e;
    @(negedge clk);
    initReq = isInit | both;
    exitReq = !isInit | both;
    @(negedge clk);
    for (int k = 0; k <= t + 1; k++) begin
      e = expectAt(cur, isInit, k);
      if (both) check("R10", e);
      else if (injected) check("R9", e);
      else if (k >= t) check("R8", e);
      else check(tagFor(isInit, k), e);
      initReq = 1'b0;
      exitReq = 1'b0;
      if (k >= 1 && k <= t - 1 && ($urandom % 100) < injectPct) begin
        injected = 1'b1;
        if ($urandom % 2 == 0) initReq = 1'b1; else exitReq = 1'b1;
      end
      @(negedge clk);
    end
    cur = expectAt(cur, isInit, t + 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    cur = resetVec();
    repeat (3) @(negedge clk);
    check("R1", resetVec());
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", resetVec());

    // exit straight from the power-down state
    runSeq(1'b0, 1'b0, 0);
    // plain init, then init again over an initialised PHY
    runSeq(1'b1, 1'b0, 0);
    runSeq(1'b1, 1'b0, 0);
    // exit, then simultaneous requests must start init
    runSeq(1'b0, 1'b0, 0);
    runSeq(1'b1, 1'b1, 0);

    // random sequences with stray requests while busy
    for (int i = 0; i < 6; i++) begin
      runSeq(($urandom % 3) != 0, 1'b0, 2);
      repeat ($urandom % 5) @(negedge clk);
      check("R9", cur);
    end

    // reset asserted in the middle of init
    @(negedge clk);
    initReq = 1'b1;
    @(negedge clk);
    initReq = 1'b0;
    repeat (20) @(negedge clk);
    #1 rstN = 1'b0;
    #0.5 check("R1", resetVec());
    @(negedge clk);
    rstN = 1'b1;
    cur = resetVec();
    repeat (2) @(negedge clk);
    check("R1", resetVec());
    runSeq(1'b1, 1'b0, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule